// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates one virtual address at a time by walking a two-level page table kept in memory. A walk starts with a one-cycle start strobe that carries the virtual address. The block latches that address and the table base, then reads a first-level descriptor through a read port that allows one request at a time. The descriptor either ends the walk or points to a second-level table, and in that case the block reads one more descriptor. A walk can end in one of four page sizes: 1 MB, 16 MB, 64 KB or 4 KB. The attribute fields sit at different bit positions in first-level and second-level descriptors, and the block extracts them from the correct positions for each level.

When the walk ends, the block pulses a done flag. On a successful walk it also presents the translated physical address, a 2-bit page size code, and a tag word and a data word packed for a TLB fill. On a failed walk it raises a fault flag and captures the offending virtual address. The fault flag and all result values stay unchanged until a new walk is accepted. The fault address changes only when a fault occurs.

Top module: `pw_walker`

## Requirements
- R1: The table base keeps only bits [31:14]; the bits below 14 are cleared when the base is captured at walk start. The first read goes to {base[31:14], va[31:20], 2'b00}.
- R2: `rd_req` rises in the cycle after an accepted start. While it waits for `rd_valid`, it stays high and `rd_addr` stays unchanged. It drops in the cycle after the response is accepted, so only one read is ever outstanding.
- R3: A first-level descriptor with [1:0]=2 and bit 18 clear is a 1 MB page, size code 0. Its physical base is in bits [31:20]. Its endianness bit is bit 15, its 2-bit element size is in bits [11:10] and its mixed flag is bit 17. The physical address takes va[19:0] as the offset.
- R4: A first-level descriptor with [1:0]=2 and bit 18 set is a 16 MB page, size code 3. Its base is in bits [31:24] and the offset is va[23:0]. Its attributes sit at the same positions as in R3.
- R5: A first-level descriptor with [1:0]=1 leads to a second read at {desc[31:10], va[19:12], 2'b00}.
- R6: A second-level descriptor with [1:0]=2 is a 4 KB page, size code 2. Its base is in bits [31:12]. Its endianness bit is bit 9, its element size is in bits [5:4] and its mixed flag is bit 11. The offset is va[11:0].
- R7: A second-level descriptor with [1:0]=1 is a 64 KB page, size code 1. Its base is in bits [31:16], the offset is va[15:0], and its attributes sit at the R6 positions.
- R8: A descriptor type of 0 or 3 at either level ends the walk with `walk_fault` high in the done cycle and `fault_va` equal to the full virtual address. A first-level fault issues no second read.
- R9: A successful walk leaves `walk_fault` low and does not change `fault_va`.
- R10: The TLB words are packed as follows. The tag word holds the virtual address with bits below the page size cleared in [31:12], zeros in [11:4], 0 in bit 3, 1 in bit 2 and the size code in [1:0]. The data word holds the physical frame (base with bits below the page size cleared) in [31:12], the endianness bit in bit 9, the element size in [8:7], the mixed flag in bit 6, and zeros elsewhere.
- R11: Each level spends exactly one decode cycle after its response is accepted. `walk_done` is high for one cycle, in the second cycle after the final response is accepted. `walk_busy` is low in the cycle after that.
- R12: A start strobe seen while a walk is in progress has no effect on that walk or on its results.
- R13: During reset and right after it, `rd_req`, `walk_busy`, `walk_done` and `walk_fault` are low, and `fault_va`, `page_code`, `pa_out`, `tlb_tag` and `tlb_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ttb_base | input | 32 | First-level table base, captured at walk start |
| walk_start | input | 1 | Start strobe, taken only when idle |
| walk_va | input | 32 | Virtual address to translate |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Byte address of the descriptor |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Descriptor word |
| walk_busy | output | 1 | A walk is in progress |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| walk_fault | output | 1 | Last walk faulted |
| fault_va | output | 32 | Virtual address of the last faulting walk |
| page_code | output | 2 | 0=1 MB, 1=64 KB, 2=4 KB, 3=16 MB |
| pa_out | output | 32 | Translated physical address |
| tlb_tag | output | 32 | Packed TLB tag word |
| tlb_data | output | 32 | Packed TLB data word |

## Verification
The block has no tunable sizes, so the bench builds it with its fixed 32-bit descriptor format. It models the memory with a table that the bench computes for all 4096 first-level slots, so that each walk gets a different mix of leaf kinds, fault types and read latencies. It sweeps every first-level slot once and every second-level slot of one coarse table. This exercises every descriptor type at both levels, the replicated 16 MB and 64 KB entries, and unused descriptor bits set to nonzero junk values. Two table bases with junk in the low bits check the masking. Directed walks cover a start strobe during a walk and the fault address being held across successful walks.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int DW      = 32;
  localparam int TTB_LSB = 14;
  localparam int SEC_LSB = 20;
  localparam int SUP_LSB = 24;
  localparam int LRG_LSB = 16;
  localparam int SML_LSB = 12;
  localparam int CT_LSB  = 10;
  localparam int SUP_BIT = 18;
  // first-level attribute positions
  localparam int L1_END_BIT = 15;
  localparam int L1_MIX_BIT = 17;
  localparam int L1_ES_LSB  = 10;
  // second-level attribute positions
  localparam int L2_END_BIT = 9;
  localparam int L2_MIX_BIT = 11;
  localparam int L2_ES_LSB  = 4;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_SUPER   = 2'd3
  } pg_code_e;

  typedef enum logic [1:0] {L1_BAD, L1_SEC, L1_SUP, L1_TBL} l1_kind_e;
  typedef enum logic [1:0] {L2_BAD, L2_LRG, L2_SML} l2_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_DEC1, S_RD2, S_DEC2, S_DONE
  } walk_st_e;

  typedef struct packed {
    logic       endian;
    logic [1:0] elem;
    logic       mixed;
  } pg_attr_t;

  function automatic logic [DW-1:0] keep_above(input int unsigned lsb);
    logic [DW-1:0] ones;
    ones = '1;
    return ones << lsb;
  endfunction

  function automatic logic [DW-1:0] page_mask(input pg_code_e c);
    case (c)
      PG_SECTION: return keep_above(SEC_LSB);
      PG_SUPER:   return keep_above(SUP_LSB);
      PG_LARGE:   return keep_above(LRG_LSB);
      default:    return keep_above(SML_LSB);
    endcase
  endfunction

  function automatic logic [DW-1:0] l1_addr(input logic [DW-1:0] ttb,
                                             input logic [DW-1:0] va);
    return {ttb[DW-1:TTB_LSB], va[DW-1:SEC_LSB], 2'b00};
  endfunction

  function automatic logic [DW-1:0] l2_addr(input logic [DW-1:0] cbase,
                                             input logic [DW-1:0] va);
    return {cbase[DW-1:CT_LSB], va[SEC_LSB-1:SML_LSB], 2'b00};
  endfunction

  function automatic logic [DW-1:0] phys_of(input logic [DW-1:0] base,
                                             input logic [DW-1:0] va,
                                             input pg_code_e c);
    logic [DW-1:0] m;
    m = page_mask(c);
    return (base & m) | (va & ~m);
  endfunction

  function automatic logic [DW-1:0] tag_word(input logic [DW-1:0] va,
                                              input pg_code_e c);
    logic [DW-1:0] t;
    t = va & page_mask(c);
    return {t[DW-1:SML_LSB], 8'h00, 1'b0, 1'b1, c};
  endfunction

  function automatic logic [DW-1:0] data_word(input logic [DW-1:0] base,
                                               input pg_attr_t a,
                                               input pg_code_e c);
    logic [DW-1:0] t;
    t = base & page_mask(c);
    return {t[DW-1:SML_LSB], 2'b00, a.endian, a.elem, a.mixed, 6'b000000};
  endfunction
endpackage

// File: rtl/pw_l1_decode.sv
module pw_l1_decode
  import pw_pkg::*;
(
  input  logic [DW-1:0] desc,
  output l1_kind_e      kind,
  output logic [DW-1:0] base,
  output pg_attr_t      attr
);
  logic unused_l1_bits;
  assign unused_l1_bits = ^{desc[19], desc[16], desc[14:12], desc[9:2]};

  always_comb begin
    attr = '{endian: desc[L1_END_BIT],
             elem:   desc[L1_ES_LSB+1:L1_ES_LSB],
             mixed:  desc[L1_MIX_BIT]};
    kind = L1_BAD;
    base = '0;
    case (desc[1:0])
      2'd2: begin
        if (desc[SUP_BIT]) begin
          kind = L1_SUP;
          base = {desc[DW-1:SUP_LSB], {SUP_LSB{1'b0}}};
        end else begin
          kind = L1_SEC;
          base = {desc[DW-1:SEC_LSB], {SEC_LSB{1'b0}}};
        end
      end
      2'd1: begin
        kind = L1_TBL;
        base = {desc[DW-1:CT_LSB], {CT_LSB{1'b0}}};
      end
      default: begin
        kind = L1_BAD;
        base = '0;
      end
    endcase
  end
endmodule

// File: rtl/pw_l2_decode.sv
module pw_l2_decode
  import pw_pkg::*;
(
  input  logic [DW-1:0] desc,
  output l2_kind_e      kind,
  output logic [DW-1:0] base,
  output pg_attr_t      attr
);
  logic unused_l2_bits;
  assign unused_l2_bits = ^{desc[10], desc[8:6], desc[3:2]};

  always_comb begin
    attr = '{endian: desc[L2_END_BIT],
             elem:   desc[L2_ES_LSB+1:L2_ES_LSB],
             mixed:  desc[L2_MIX_BIT]};
    case (desc[1:0])
      2'd2: begin
        kind = L2_SML;
        base = {desc[DW-1:SML_LSB], {SML_LSB{1'b0}}};
      end
      2'd1: begin
        kind = L2_LRG;
        base = {desc[DW-1:LRG_LSB], {LRG_LSB{1'b0}}};
      end
      default: begin
        kind = L2_BAD;
        base = '0;
      end
    endcase
  end
endmodule

// File: rtl/pw_tlb_pack.sv
module pw_tlb_pack
  import pw_pkg::*;
(
  input  logic [DW-1:0] va,
  input  logic [DW-1:0] base,
  input  pg_attr_t      attr,
  input  pg_code_e      code,
  output logic [DW-1:0] pa,
  output logic [DW-1:0] tag,
  output logic [DW-1:0] data
);
  assign pa   = phys_of(base, va, code);
  assign tag  = tag_word(va, code);
  assign data = data_word(base, attr, code);
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ttb_base,
  input  logic          walk_start,
  input  logic [DW-1:0] walk_va,
  output logic          rd_req,
  output logic [DW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          walk_busy,
  output logic          walk_done,
  output logic          walk_fault,
  output logic [DW-1:0] fault_va,
  output logic [1:0]    page_code,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] tlb_tag,
  output logic [DW-1:0] tlb_data
);
  localparam logic [DW-1:0] TTB_MASK = {{(DW-TTB_LSB){1'b1}}, {TTB_LSB{1'b0}}};

  walk_st_e      st;
  logic [DW-1:0] va_q, ttb_q, desc_q, cbase_q;

  l1_kind_e      k1;
  logic [DW-1:0] b1;
  pg_attr_t      a1;
  l2_kind_e      k2;
  logic [DW-1:0] b2;
  pg_attr_t      a2;

  pg_code_e      leaf_code;
  logic [DW-1:0] leaf_base;
  pg_attr_t      leaf_attr;
  logic [DW-1:0] pk_pa, pk_tag, pk_data;

  // named internal events, observed by the bound checker
  logic in_dec1, in_dec2;
  logic l1_accept, l2_accept;
  logic leaf_event, fault_event;

  pw_l1_decode u_l1 (.desc(desc_q), .kind(k1), .base(b1), .attr(a1));
  pw_l2_decode u_l2 (.desc(desc_q), .kind(k2), .base(b2), .attr(a2));

  always_comb begin
    if (st == S_DEC1) begin
      leaf_base = b1;
      leaf_attr = a1;
      leaf_code = (k1 == L1_SUP) ? PG_SUPER : PG_SECTION;
    end else begin
      leaf_base = b2;
      leaf_attr = a2;
      leaf_code = (k2 == L2_LRG) ? PG_LARGE : PG_SMALL;
    end
  end

  pw_tlb_pack u_pack (
    .va(va_q), .base(leaf_base), .attr(leaf_attr), .code(leaf_code),
    .pa(pk_pa), .tag(pk_tag), .data(pk_data)
  );

  assign in_dec1     = (st == S_DEC1);
  assign in_dec2     = (st == S_DEC2);
  assign l1_accept   = (st == S_RD1) && rd_valid;
  assign l2_accept   = (st == S_RD2) && rd_valid;
  assign leaf_event  = (in_dec1 && (k1 == L1_SEC || k1 == L1_SUP)) ||
                       (in_dec2 && (k2 != L2_BAD));
  assign fault_event = (in_dec1 && (k1 == L1_BAD)) ||
                       (in_dec2 && (k2 == L2_BAD));

  assign rd_req    = (st == S_RD1) || (st == S_RD2);
  assign rd_addr   = (st == S_RD2) ? l2_addr(cbase_q, va_q) : l1_addr(ttb_q, va_q);
  assign walk_busy = (st != S_IDLE);
  assign walk_done = (st == S_DONE);

  logic unused_low;
  assign unused_low = ^{ttb_q[TTB_LSB-1:0], cbase_q[CT_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      ttb_q      <= '0;
      desc_q     <= '0;
      cbase_q    <= '0;
      walk_fault <= 1'b0;
      fault_va   <= '0;
      page_code  <= '0;
      pa_out     <= '0;
      tlb_tag    <= '0;
      tlb_data   <= '0;
    end else begin
      case (st)
        S_IDLE: if (walk_start) begin
          va_q       <= walk_va;
          ttb_q      <= ttb_base & TTB_MASK;
          walk_fault <= 1'b0;
          st         <= S_RD1;
        end
        S_RD1: if (l1_accept) begin
          desc_q <= rd_data;
          st     <= S_DEC1;
        end
        S_DEC1: begin
          if (k1 == L1_TBL) begin
            cbase_q <= b1;
            st      <= S_RD2;
          end else begin
            st <= S_DONE;
          end
        end
        S_RD2: if (l2_accept) begin
          desc_q <= rd_data;
          st     <= S_DEC2;
        end
        S_DEC2:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase

      if (leaf_event) begin
        page_code <= leaf_code;
        pa_out    <= pk_pa;
        tlb_tag   <= pk_tag;
        tlb_data  <= pk_data;
      end
      if (fault_event) begin
        walk_fault <= 1'b1;
        fault_va   <= va_q;
      end
    end
  end
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_start,
  input logic        walk_busy,
  input logic        walk_done,
  input logic        walk_fault,
  input logic [31:0] fault_va,
  input logic        rd_req,
  input logic [31:0] rd_addr,
  input logic        rd_valid,
  input logic        leaf_event,
  input logic        fault_event
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid |=> !rd_req);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done && !walk_busy);

  // R11
  decode_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leaf_event || fault_event) |=> walk_done);

  // R8
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_fault) |-> walk_done);

  // R9
  fault_va_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_event |=> $stable(fault_va));

  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start && walk_busy && !walk_done |=> walk_busy);

  // R2
  no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> !rd_req);
endmodule

bind pw_walker pw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_busy(walk_busy),
  .walk_done(walk_done), .walk_fault(walk_fault), .fault_va(fault_va),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .leaf_event(leaf_event), .fault_event(fault_event)
);

// File: tb/pw_walker_tb.sv
`timescale 1ns/1ps
module pw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ttb_base = 32'h0010_3ABC;
  logic        walk_start = 1'b0;
  logic [31:0] walk_va = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        walk_busy, walk_done, walk_fault;
  logic [31:0] fault_va, pa_out, tlb_tag, tlb_data;
  logic [1:0]  page_code;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [31:0] ttb_aligned = 32'h0010_0000;
  logic [31:0] last_fault = 32'h0;

  always #2.5 clk = ~clk;

  pw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .ttb_base(ttb_base), .walk_start(walk_start),
    .walk_va(walk_va), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .walk_busy(walk_busy), .walk_done(walk_done),
    .walk_fault(walk_fault), .fault_va(fault_va), .page_code(page_code),
    .pa_out(pa_out), .tlb_tag(tlb_tag), .tlb_data(tlb_data)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // memory image computed from the address
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [11:0] idx, cidx;
    logic [7:0]  s;
    logic [5:0]  g;
    if (a[31:14] == ttb_aligned[31:14]) begin
      idx = a[13:2];
      if (idx[11:10] == 2'b11) begin
        g = idx[9:4];
        return {2'b10, g, 4'hA, 1'b0, 1'b1, g[3], 1'b0, g[0], 3'b000, g[2:1], 8'h00, 2'b10};
      end
      case (idx[1:0])
        2'd0: return {idx, 18'h0, 2'b00};
        2'd3: return {20'hFFFFF, idx[9:0], 2'b11};
        2'd2: return {idx ^ 12'h5A5, 1'b0, 1'b0, idx[4], 1'b0, idx[5], 3'b101, idx[7:6], 8'h00, 2'b10};
        default: return {10'h100, idx, 8'hE4, 2'b01};
      endcase
    end else if (a[31:22] == 10'h100) begin
      cidx = a[21:10];
      s    = a[9:2];
      if (s[7:6] == 2'b11)
        return {cidx[7:0], 2'b11, s[5:4], 4'h9, 4'h0, cidx[3], 1'b0, cidx[2], 3'b000, s[5:4], 2'b00, 2'b01};
      case (s[1:0])
        2'd0: return 32'h0;
        2'd3: return {s, 22'h0, 2'b11};
        default: return {cidx[7:0], s, 4'h5, s[2], 1'b0, s[3], 3'b101, s[5:4], 2'b00, 2'b10};
      endcase
    end
    return 32'hDEAD_BEE0;
  endfunction

  // expected result from the table layout the memory model follows
  task automatic expect_of(input logic [31:0] va, output bit flt, output bit two,
                           output logic [31:0] pa, output logic [1:0] code,
                           output logic en, output logic [1:0] es, output logic mx);
    logic [11:0] idx;
    logic [7:0]  s;
    logic [5:0]  g;
    idx = va[31:20]; s = va[19:12];
    flt = 0; two = 0; pa = 0; code = 0; en = 0; es = 0; mx = 0;
    if (idx[11:10] == 2'b11) begin
      g = idx[9:4]; code = 2'd3; pa = {2'b10, g, va[23:0]};
      en = g[0]; es = g[2:1]; mx = g[3];
    end else if (idx[1:0] == 2'd0 || idx[1:0] == 2'd3) begin
      flt = 1;
    end else if (idx[1:0] == 2'd2) begin
      code = 2'd0; pa = {idx ^ 12'h5A5, va[19:0]};
      en = idx[5]; es = idx[7:6]; mx = idx[4];
    end else begin
      two = 1;
      if (s[7:6] == 2'b11) begin
        code = 2'd1; pa = {idx[7:0], 2'b11, s[5:4], 4'h9, va[15:0]};
        en = idx[2]; es = s[5:4]; mx = idx[3];
      end else if (s[1:0] == 2'd0 || s[1:0] == 2'd3) begin
        flt = 1;
      end else begin
        code = 2'd2; pa = {idx[7:0], s, 4'h5, va[11:0]};
        en = s[3]; es = s[5:4]; mx = s[2];
      end
    end
  endtask

  task automatic respond(input int lat, input bit poke, input logic [31:0] va);
    logic [31:0] a0;
    a0 = rd_addr;
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 0) begin
        walk_start = 1'b1;   // R12: strobe during a walk
        walk_va = va ^ 32'h0010_0000;
      end
      @(negedge clk);
      walk_start = 1'b0;
      chk(rd_req === 1'b1 && rd_addr === a0, "R2 hold", rd_addr, a0);
    end
    rd_valid = 1'b1;
    rd_data = mem_word(rd_addr);
    @(negedge clk);
    rd_valid = 1'b0;
    rd_data = 32'h5555_AAAA;
    chk(rd_req === 1'b0, "R2 drop", {31'b0, rd_req}, 32'h0);
    chk(walk_done === 1'b0, "R11 decode cycle", {31'b0, walk_done}, 32'h0);
  endtask

  task automatic walk(input logic [31:0] va, input int lat1, input int lat2, input bit poke);
    bit flt, two;
    logic [31:0] pa, m, etag, edata, el1, el2;
    logic [1:0]  code;
    logic en, mx;
    logic [1:0] es;
    string rq;
    expect_of(va, flt, two, pa, code, en, es, mx);
    el1 = {ttb_aligned[31:14], va[31:20], 2'b00};
    el2 = {10'h100, va[31:20], va[19:12], 2'b00};
    @(negedge clk);
    walk_start = 1'b1; walk_va = va;
    @(negedge clk);
    walk_start = 1'b0; walk_va = ~va;
    chk(rd_req === 1'b1, "R2 req rise", {31'b0, rd_req}, 32'h1);
    chk(rd_addr === el1, "R1 l1 address", rd_addr, el1);
    respond(lat1, poke, va);
    @(negedge clk);
    if (two) begin
      chk(rd_req === 1'b1 && rd_addr === el2, "R5 l2 address", rd_addr, el2);
      respond(lat2, 1'b0, va);
      @(negedge clk);
    end else begin
      chk(rd_req === 1'b0, "R8 no second read", {31'b0, rd_req}, 32'h0);
    end
    chk(walk_done === 1'b1, "R11 done timing", {31'b0, walk_done}, 32'h1);
    chk(walk_fault === flt, "R8 fault flag", {31'b0, walk_fault}, {31'b0, flt});
    if (flt) begin
      chk(fault_va === va, "R8 fault address", fault_va, va);
      last_fault = va;
    end else begin
      case (code)
        2'd0: begin rq = "R3"; m = 32'hFFF0_0000; end
        2'd3: begin rq = "R4"; m = 32'hFF00_0000; end
        2'd1: begin rq = "R7"; m = 32'hFFFF_0000; end
        default: begin rq = "R6"; m = 32'hFFFF_F000; end
      endcase
      etag  = {(va & m) >> 12, 8'h00, 1'b0, 1'b1, code};
      edata = {(pa & m) >> 12, 2'b00, en, es, mx, 6'b0};
      chk(pa_out === pa, {rq, " physical address"}, pa_out, pa);
      chk(page_code === code, {rq, " size code"}, {30'b0, page_code}, {30'b0, code});
      chk(tlb_tag === etag, "R10 tag word", tlb_tag, etag);
      chk(tlb_data === edata, {"R10 data word ", rq}, tlb_data, edata);
      chk(fault_va === last_fault, "R9 fault address held", fault_va, last_fault);
    end
    @(negedge clk);
    chk(walk_done === 1'b0 && walk_busy === 1'b0, "R11 back to idle",
        {30'b0, walk_done, walk_busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    walk_start = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk(rd_req === 1'b0 && walk_busy === 1'b0 && walk_done === 1'b0 && walk_fault === 1'b0,
        "R13 flags in reset", {28'b0, rd_req, walk_busy, walk_done, walk_fault}, 32'h0);
    walk_start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(walk_busy === 1'b0 && rd_req === 1'b0, "R13 idle after reset",
        {30'b0, walk_busy, rd_req}, 32'h0);
    chk(fault_va === 32'h0 && pa_out === 32'h0 && page_code === 2'b0,
        "R13 results zero", fault_va | pa_out, 32'h0);
    chk(tlb_tag === 32'h0 && tlb_data === 32'h0, "R13 tlb words zero",
        tlb_tag | tlb_data, 32'h0);

    // sweep every first-level slot
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] va;
      logic [7:0] sl;
      logic [11:0] off;
      sl = 8'(i * 37);
      off = 12'(i * 13 + 7);
      va = {12'(i), sl, off};
      walk(va, i % 3, (i + 1) % 3, 1'b0);
    end

    // sweep every second-level slot of one coarse table
    for (int s = 0; s < 256; s++) begin
      walk({12'h0D5, 8'(s), 12'hB3C}, s % 2, (s + 2) % 4, 1'b0);
    end

    // R12: strobes during walks of each kind
    walk(32'h0023_4567, 2, 0, 1'b1);
    walk(32'h0D51_0ABC, 3, 1, 1'b1);
    walk(32'hC341_2345, 1, 0, 1'b1);

    // R9: fault then successes keep the fault address
    walk(32'h0040_1234, 0, 0, 1'b0);
    walk(32'h0021_FFFF, 4, 0, 1'b0);
    walk(32'h0D5E_7001, 0, 5, 1'b0);

    // R1: a second table base with junk low bits
    ttb_base = 32'h7FFF_FFFF;
    ttb_aligned = 32'h7FFF_C000;
    walk(32'h0061_0010, 1, 0, 1'b0);
    walk(32'hFFF0_1234, 0, 0, 1'b0);
    walk(32'h0D53_3333, 2, 2, 1'b0);
    walk(32'h0030_0000, 0, 0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule